// File: doc/BRIEF.md
# Dual Q15 SIMD Fractional Multiplier

This block multiplies two pairs of signed 16-bit lanes packed into two 32-bit operand words. It produces two 32-bit products per accepted operation. A 2-bit pairing option picks which lane of operand B meets which lane of operand C. A group bit and a 2-bit sub-opcode pick one of three modes:

- **Integer mode:** the full signed products are returned.
- **Wide Q15 mode:** the products are scaled for fractional arithmetic, may be rounded, and are returned as two full words.
- **Packed Q15 mode:** the rounded high halves of both products are joined into one word.

Two control bits, rounding enable and bias select, come from the surrounding control register. Bias select only matters in packed mode, where it chooses between round-half-up and round-half-to-even.

Operations enter on a valid/ready handshake and leave on a second valid/ready handshake.

- **Input side:** `in_ready_o` is high whenever the one-entry output register is empty or is being drained in the same cycle. An operation is taken on any rising edge where `in_valid_i` and `in_ready_o` are both high.
- **Output side:** the result appears one cycle after it is taken. It stays frozen while `out_ready_i` is low.

A reserved sub-opcode produces no result. It only pulses `rsvd_o`.

Top module: `dq15_mul`

## Requirements
- R1: Lane pairing by `opt_i` is as follows, where the first factor of each product is taken from operand B:

  | `opt_i` | First product | Second product |
  |---|---|---|
  | 0 | B[31:16]×C[31:16] | B[15:0]×C[15:0] |
  | 1 | B[15:0]×C[31:16] | B[15:0]×C[15:0] |
  | 2 | B[31:16]×C[31:16] | B[31:16]×C[15:0] |
  | 3 | B[15:0]×C[31:16] | B[31:16]×C[15:0] |

  Every lane is treated as signed two's complement.
- R2: With `op_grp_i`=0 (integer mode), `res_a_o` holds the first signed 32-bit product and `res_d_o` the second. `res_d_we_o` is 1. `rnd_en_i`, `bias_sel_i` and `sub_op_i` have no effect.
- R3: With `op_grp_i`=1 (fractional modes), each product is shifted left by one bit. With `rnd_en_i`=0 (control bit 1), no rounding is applied.
- R4: With `op_grp_i`=1 and `sub_op_i`=1 (wide mode), `res_a_o`/`res_d_o` hold the first/second shifted products. If `rnd_en_i`=1, 0x8000 is added to each, whatever the value of `bias_sel_i`.
- R5: With `sub_op_i`=0 (packed mode), `rnd_en_i`=1 and `bias_sel_i`=1 (control bit 2), 0x8000 is added to each shifted product.
- R6: In packed mode with `rnd_en_i`=1 and `bias_sel_i`=0, a shifted product whose low 17 bits equal exactly 0x08000 is left unchanged. Every other shifted product gets 0x8000 added.
- R7: In packed mode, `res_a_o` holds the first result's bits 31:16 in bits 31:16 and the second result's bits 31:16 in bits 15:0. `res_d_we_o` is 0 and `res_d_o` is zero.
- R8: With `op_grp_i`=1 and `sub_op_i` equal to 2 or 3, an accepted operation pulses `rsvd_o` for one cycle and raises no `out_valid_o`.
- R9: The shift and the rounding addition wrap modulo 2^32 with no saturation. For example, -32768×-32768 in wide mode with rounding gives 0x80008000.
- R10: The result is presented one cycle after acceptance. With `out_ready_i` high, `out_valid_o` is a one-cycle pulse. While `out_valid_o`=1 and `out_ready_i`=0, all result outputs hold and `in_ready_o` is 0.
- R11: After reset, `out_valid_o`, `res_d_we_o` and `rsvd_o` are 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken this cycle |
| op_grp_i | input | 1 | 0 integer mode, 1 fractional group |
| sub_op_i | input | 2 | Fractional variant: 0 packed, 1 wide, 2/3 reserved |
| opt_i | input | 2 | Lane pairing option |
| rnd_en_i | input | 1 | Control bit 1: rounding enable |
| bias_sel_i | input | 1 | Control bit 2: biased rounding in packed mode |
| opb_i | input | 32 | Operand B, two signed lanes |
| opc_i | input | 32 | Operand C, two signed lanes |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| res_a_o | output | 32 | First or packed result |
| res_d_o | output | 32 | Second result |
| res_d_we_o | output | 1 | Second result is to be written |
| rsvd_o | output | 1 | Reserved sub-opcode was accepted |

## Verification
The hardest case to reach is the exact tie in round-to-even, where a shifted product has its low 17 bits equal to exactly 0x08000. A random operand almost never lands there. The sweep therefore builds its lane values from small factors and powers of two, such as 1, 3 and 0x4000. The product 0x4000×1 reaches the tie with an even upper part, and 0x4000×3 reaches the odd neighbour that must round up. These operands are crossed with all four pairings and both bias settings. Directed cases add the -1.0×-1.0 wrap and a result held under back-pressure while a new operation waits.

// File: rtl/dq15_pkg.sv
package dq15_pkg;
  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_PACK = 2'd1,
    MODE_WIDE = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  function automatic mode_e decode_mode(input logic grp, input logic [1:0] sub);
    if (!grp)              return MODE_INT;
    else if (sub == 2'd0)  return MODE_PACK;
    else if (sub == 2'd1)  return MODE_WIDE;
    else                   return MODE_RSVD;
  endfunction
endpackage

// File: rtl/dq15_lane_pick.sv
module dq15_lane_pick #(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic [WORD_W-1:0]        opb_i,
  input  logic [WORD_W-1:0]        opc_i,
  input  logic [1:0]               opt_i,
  output logic signed [LANE_W-1:0] fb_o [2],
  output logic signed [LANE_W-1:0] fc_o [2]
);
  logic signed [LANE_W-1:0] b_lo, b_hi, c_lo, c_hi;

  assign b_lo = opb_i[LANE_W-1:0];
  assign b_hi = opb_i[WORD_W-1:LANE_W];
  assign c_lo = opc_i[LANE_W-1:0];
  assign c_hi = opc_i[WORD_W-1:LANE_W];

  // option bit 0 picks the B lane of the first product, bit 1 that of the second
  always_comb begin
    fb_o[0] = opt_i[0] ? b_lo : b_hi;
    fc_o[0] = c_hi;
    fb_o[1] = opt_i[1] ? b_hi : b_lo;
    fc_o[1] = c_lo;
  end
endmodule

// File: rtl/dq15_prod_round.sv
module dq15_prod_round #(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic signed [LANE_W-1:0] fb_i,
  input  logic signed [LANE_W-1:0] fc_i,
  input  logic                     frac_i,
  input  logic                     rnd_en_i,
  input  logic                     even_i,
  output logic [WORD_W-1:0]        res_o
);
  localparam logic [WORD_W-1:0] HALF = {{LANE_W{1'b0}}, 1'b1, {(LANE_W-1){1'b0}}};

  logic signed [WORD_W-1:0] prod;
  logic [WORD_W-1:0]        scaled;
  logic                     tie, add_half;

  always_comb begin
    prod     = WORD_W'(fb_i) * WORD_W'(fc_i);
    scaled   = frac_i ? (prod <<< 1) : prod;
    tie      = (scaled[LANE_W:0] == HALF[LANE_W:0]);
    add_half = frac_i && rnd_en_i && !(even_i && tie);
    res_o    = add_half ? scaled + HALF : scaled;
  end

  // R3
  always_comb begin
    if (frac_i && !rnd_en_i) begin
      noround_lsb_chk: assert (res_o[0] == 1'b0);
    end
  end
endmodule

// File: rtl/dq15_mul.sv
module dq15_mul
  import dq15_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              op_grp_i,
  input  logic [1:0]        sub_op_i,
  input  logic [1:0]        opt_i,
  input  logic              rnd_en_i,
  input  logic              bias_sel_i,
  input  logic [WORD_W-1:0] opb_i,
  input  logic [WORD_W-1:0] opc_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] res_a_o,
  output logic [WORD_W-1:0] res_d_o,
  output logic              res_d_we_o,
  output logic              rsvd_o
);
  mode_e                    mode;
  logic signed [LANE_W-1:0] fb [2];
  logic signed [LANE_W-1:0] fc [2];
  logic [WORD_W-1:0]        prd [2];
  logic                     frac, even, accept, load;
  logic [WORD_W-1:0]        nxt_a, nxt_d;

  assign mode   = decode_mode(op_grp_i, sub_op_i);
  assign frac   = (mode != MODE_INT);
  assign even   = (mode == MODE_PACK) && !bias_sel_i;
  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept = in_valid_i && in_ready_o;
  assign load   = accept && (mode != MODE_RSVD);

  dq15_lane_pick #(.LANE_W(LANE_W)) u_pick (
    .opb_i(opb_i), .opc_i(opc_i), .opt_i(opt_i), .fb_o(fb), .fc_o(fc)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    dq15_prod_round #(.LANE_W(LANE_W)) u_rnd (
      .fb_i(fb[g]), .fc_i(fc[g]), .frac_i(frac), .rnd_en_i(rnd_en_i),
      .even_i(even), .res_o(prd[g])
    );
  end

  always_comb begin
    if (mode == MODE_PACK) begin
      nxt_a = {prd[0][WORD_W-1:LANE_W], prd[1][WORD_W-1:LANE_W]};
      nxt_d = '0;
    end else begin
      nxt_a = prd[0];
      nxt_d = prd[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      res_a_o     <= '0;
      res_d_o     <= '0;
      res_d_we_o  <= 1'b0;
      rsvd_o      <= 1'b0;
    end else begin
      rsvd_o <= accept && (mode == MODE_RSVD);
      if (load) begin
        out_valid_o <= 1'b1;
        res_a_o     <= nxt_a;
        res_d_o     <= nxt_d;
        res_d_we_o  <= (mode != MODE_PACK);
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
        res_d_we_o  <= 1'b0;
      end
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(res_a_o)
                                       && $stable(res_d_o) && $stable(res_d_we_o)));
  // R10
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(in_valid_i));
  // R8
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsvd_o && !$past(out_valid_o)) |-> !out_valid_o);
  // R7
  dwe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_d_we_o |-> out_valid_o);
  // R7
  pack_dzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !res_d_we_o) |-> (res_d_o == '0));
endmodule

// File: tb/dq15_mul_bench.sv
`timescale 1ns/1ps
module dq15_mul_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, op_grp = 1'b0, rnd_en = 1'b0, bias_sel = 1'b0;
  logic [1:0] sub_op = 2'd0, opt = 2'd0;
  logic [31:0] opb = '0, opc = '0, res_a, res_d;
  logic out_valid, out_ready = 1'b1, res_d_we, rsvd;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dq15_mul u_dq15_mul (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_grp_i(op_grp), .sub_op_i(sub_op), .opt_i(opt), .rnd_en_i(rnd_en),
    .bias_sel_i(bias_sel), .opb_i(opb), .opc_i(opc), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .res_a_o(res_a), .res_d_o(res_d),
    .res_d_we_o(res_d_we), .rsvd_o(rsvd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint lane(input logic [31:0] w, input bit hi);
    logic signed [15:0] v;
    v = hi ? w[31:16] : w[15:0];
    return longint'(v);
  endfunction

  // reference from the requirements: k = product index, md 0 int, 1 packed, 2 wide
  function automatic logic [31:0] ref_prod(input int k, input int md, input logic [1:0] o,
                                           input logic [31:0] b, input logic [31:0] c,
                                           input bit rn, input bit bs);
    longint p;
    if (k == 0) p = lane(b, !o[0]) * lane(c, 1'b1);
    else        p = lane(b, o[1]) * lane(c, 1'b0);
    p = p & 64'hFFFF_FFFF;
    if (md != 0) begin
      p = (p * 2) & 64'hFFFF_FFFF;
      if (rn && !(md == 1 && !bs && (p & 64'h1FFFF) == 64'h08000))
        p = (p + 64'h8000) & 64'hFFFF_FFFF;
    end
    return p[31:0];
  endfunction

  task automatic issue(input bit g, input logic [1:0] s, input logic [1:0] o,
                       input bit rn, input bit bs, input logic [31:0] b, input logic [31:0] c);
    op_grp = g; sub_op = s; opt = o; rnd_en = rn; bias_sel = bs; opb = b; opc = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_check(input int md, input logic [1:0] o, input bit rn, input bit bs,
                           input logic [31:0] b, input logic [31:0] c);
    logic [31:0] e0, e1;
    string tag;
    e0 = ref_prod(0, md, o, b, c, rn, bs);
    e1 = ref_prod(1, md, o, b, c, rn, bs);
    if (md == 0)      tag = "R2";
    else if (!rn)     tag = "R3";
    else if (md == 2) tag = "R4";
    else if (bs)      tag = "R5";
    else              tag = "R6";
    issue(md != 0, (md == 2) ? 2'd1 : 2'd0, o, rn, bs, b, c);
    chk("R10 valid", {31'd0, out_valid}, 32'd1);
    if (md == 1) begin
      chk({tag, " R7 packed"}, res_a, {e0[31:16], e1[31:16]});
      chk("R7 dwe", {31'd0, res_d_we}, 32'd0);
    end else begin
      chk({tag, " R1 a"}, res_a, e0);
      chk({tag, " R1 d"}, res_d, e1);
      chk({tag, " dwe"}, {31'd0, res_d_we}, 32'd1);
    end
    @(negedge clk);
    chk("R10 pulse", {31'd0, out_valid}, 32'd0);
  endtask

  logic [15:0] vals [12] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h4000,
                             16'hC000, 16'h1234, 16'hA988, 16'h0003, 16'h0101, 16'hFFFE};

  initial begin
    #900000;
    n_fail++; n_chk++;
    $display("FAIL R10 watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk("R11 valid", {31'd0, out_valid}, 32'd0);
    chk("R11 rsvd", {31'd0, rsvd}, 32'd0);
    chk("R11 dwe", {31'd0, res_d_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready", {31'd0, in_ready}, 32'd1);

    // R1 directed pairings, integer mode
    issue(0, 2'd0, 2'd0, 1, 0, 32'h0003_0005, 32'h0007_0002);
    chk("R1 opt0 a", res_a, 32'd21); chk("R1 opt0 d", res_d, 32'd10);
    issue(0, 2'd3, 2'd1, 1, 1, 32'h0003_0005, 32'h0007_0002);
    chk("R1 opt1 a", res_a, 32'd35); chk("R1 opt1 d", res_d, 32'd10);
    issue(0, 2'd0, 2'd2, 0, 0, 32'h0003_0005, 32'h0007_0002);
    chk("R1 opt2 a", res_a, 32'd21); chk("R1 opt2 d", res_d, 32'd6);
    issue(0, 2'd0, 2'd3, 0, 0, 32'h0003_0005, 32'h0007_0002);
    chk("R1 opt3 a", res_a, 32'd35); chk("R1 opt3 d", res_d, 32'd6);

    // R6 tie cases: 0x4000*1 (tie, even) and 0x4000*3 (odd neighbour)
    issue(1, 2'd0, 2'd0, 1, 0, 32'h4000_4000, 32'h0001_0003);
    chk("R6 even tie", res_a, 32'h0000_0002);
    issue(1, 2'd0, 2'd0, 1, 1, 32'h4000_4000, 32'h0001_0003);
    chk("R5 biased tie", res_a, 32'h0001_0002);
    issue(1, 2'd1, 2'd0, 1, 0, 32'h4000_4000, 32'h0001_0003);
    chk("R4 wide a", res_a, 32'h0001_0000); chk("R4 wide d", res_d, 32'h0002_0000);

    // R9 wrap
    issue(1, 2'd1, 2'd0, 1, 0, 32'h8000_0000, 32'h8000_0000);
    chk("R9 wrap a", res_a, 32'h8000_8000);
    issue(1, 2'd0, 2'd0, 1, 1, 32'h8000_0000, 32'h8000_0000);
    chk("R9 packed wrap", res_a, 32'h8000_0000);

    // R8 reserved
    @(negedge clk);
    issue(1, 2'd2, 2'd0, 1, 0, 32'h0001_0001, 32'h0001_0001);
    chk("R8 rsvd pulse", {31'd0, rsvd}, 32'd1);
    chk("R8 no valid", {31'd0, out_valid}, 32'd0);
    issue(1, 2'd3, 2'd0, 1, 0, 32'h0001_0001, 32'h0001_0001);
    chk("R8 rsvd3", {31'd0, rsvd}, 32'd1);
    chk("R8 no valid3", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R8 rsvd clear", {31'd0, rsvd}, 32'd0);

    // R10 back-pressure
    out_ready = 1'b0;
    issue(0, 2'd0, 2'd0, 0, 0, 32'h0002_0004, 32'h0003_0005);
    repeat (3) @(negedge clk);
    chk("R10 held valid", {31'd0, out_valid}, 32'd1);
    chk("R10 held a", res_a, 32'd6);
    chk("R10 held d", res_d, 32'd20);
    chk("R10 not ready", {31'd0, in_ready}, 32'd0);
    op_grp = 0; opt = 0; opb = 32'h0001_0001; opc = 32'h0009_0008; in_valid = 1'b1;
    @(negedge clk);
    chk("R10 blocked a", res_a, 32'd6);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 drain+load a", res_a, 32'd9);
    chk("R10 drain+load d", res_d, 32'd8);
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);

    // sweep over lanes, pairings, modes and control bits
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int o = 0; o < 4; o++)
          for (int md = 0; md < 3; md++)
            for (int cb = 0; cb < 4; cb++)
              run_check(md, 2'(o), cb[0], cb[1],
                        {vals[i], vals[(i + 5) % 12]}, {vals[j], vals[(j + 7) % 12]});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule